// File: doc/BRIEF.md
# Three-Domain Main Clock Prescaler

This block takes one main clock and produces three clock-enable strobes for a processor domain, a low-power domain and a backup domain. Each strobe runs at the main rate divided by a power of two chosen with a 3-bit code n, which gives a ratio of 1 << n, from 1 up to 128. The divided clocks are not built as waveforms. Each domain's logic keeps running on the main clock and qualifies its registers with its own enable.

Software programs one domain per write, through a small port made of a strobe, a selector and a code. A setting is only legal if the backup ratio is at least the low-power ratio and the low-power ratio is at least the processor ratio. A write that would break this ordering is dropped, and a sticky error flag is raised. An accepted write is held as pending. It is copied into the active dividers only when the backup period in progress ends. At that moment one shared phase counter restarts, so all three strobes line up again and none is cut short. The ratios may be changed while the strobes are running.

Top module: `domain_prescaler`

## Requirements
- R1: After reset all three active ratios are 1 (code 0), the error flag is low and every strobe is high.
- R2: A domain holding code n reports a ratio of 1 << n on its ratio output. Its strobe is high in exactly one main clock cycle out of every 1 << n.
- R3: A write is accepted only if the resulting pending setting satisfies backup >= low-power >= processor. Otherwise the pending setting is left unchanged.
- R4: A rejected write sets the error flag. The flag stays high through later accepted writes and is cleared only by reset.
- R5: Selector encoding: 0 is the processor domain, 1 the low-power domain, 2 the backup domain. Selector 3 is ignored, with no change to any setting and no error.
- R6: Pending ratios become active on the clock edge that ends the current backup period. In the following cycle all three strobes are high together.
- R7: Every backup strobe pulse coincides with a low-power and a processor pulse, and every low-power pulse coincides with a processor pulse.
- R8: A domain with ratio 1 has its strobe high on every main clock cycle.
- R9: A backup period already in progress when a write arrives runs to its full old length before the new ratio takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one divider code |
| wr_sel | input | 2 | Domain selector (0 processor, 1 low-power, 2 backup, 3 none) |
| wr_code | input | 3 | Code n, requested ratio 1 << n |
| cpu_en | output | 1 | Processor domain clock-enable strobe |
| lp_en | output | 1 | Low-power domain clock-enable strobe |
| bkp_en | output | 1 | Backup domain clock-enable strobe |
| cpu_div | output | 8 | Active processor ratio |
| lp_div | output | 8 | Active low-power ratio |
| bkp_div | output | 8 | Active backup ratio |
| order_err | output | 1 | Sticky flag for a rejected write |

## Verification
The assertions check on every cycle that:
- the pending and active codes stay ordered;
- the strobes coincide at backup pulses;
- a ratio of 1 keeps its strobe high;
- the phase counter never passes the backup period;
- active codes change only on a wrap edge;
- rejected or ignored writes leave the pending setting untouched, and the error flag never falls while out of reset.

Only the bench scenarios can show the pulse counts over whole windows for each ratio, the exact cycle in which a write becomes active, and the full length of a backup period that a write interrupts.

// File: rtl/prescaler_pkg.sv
package prescaler_pkg;
   localparam int NDOM  = 3;
   localparam int SEL_W = 2;
   typedef enum logic [SEL_W-1:0] {
      SEL_CPU  = 2'd0,
      SEL_LP   = 2'd1,
      SEL_BKP  = 2'd2,
      SEL_NONE = 2'd3
   } dom_sel_e;
endpackage

// File: rtl/ps_cfg_regs.sv
// Pending divider codes with ordering check and sticky error.
module ps_cfg_regs
   import prescaler_pkg::*;
#(
   parameter int CODE_W = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [SEL_W-1:0]               wr_sel,
   input  logic [CODE_W-1:0]              wr_code,
   output logic [NDOM-1:0][CODE_W-1:0]    pend,
   output logic                           err
);
   logic [NDOM-1:0][CODE_W-1:0] cand;
   logic                        hit;
   logic                        ordered;
   logic                        bad;

   always_comb begin
      cand = pend;
      hit  = 1'b0;
      for (int i = 0; i < NDOM; i++) begin
         if (wr_sel == SEL_W'(i)) begin
            cand[i] = wr_code;
            hit     = wr_en;
         end
      end
      ordered = 1'b1;
      for (int i = 1; i < NDOM; i++) begin
         if (cand[i] < cand[i-1]) ordered = 1'b0;
      end
      bad = hit && !ordered;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= '0;
         err  <= 1'b0;
      end else begin
         if (hit && ordered) pend <= cand;
         if (bad)            err  <= 1'b1;
      end
   end

   generate
      for (genvar g = 1; g < NDOM; g++) begin : g_ord
         a_r3_pend_ordered: assert property (@(posedge clk) disable iff (!rst_n)
            pend[g] >= pend[g-1]);
      end
   endgenerate

   a_r3_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      bad |=> $stable(pend));
   a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
   a_r5_idle_sel: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_NONE) |=> ($stable(pend) && $stable(err)));
endmodule

// File: rtl/ps_align_counter.sv
// Shared phase counter; restarts and loads pending codes at the backup wrap.
module ps_align_counter
   import prescaler_pkg::*;
#(
   parameter int CODE_W = 3,
   localparam int CNT_W = (1 << CODE_W) - 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NDOM-1:0][CODE_W-1:0]    pend,
   output logic [NDOM-1:0][CODE_W-1:0]    act,
   output logic [CNT_W-1:0]               cnt,
   output logic                           wrap
);
   logic [CNT_W-1:0] slow_mask;

   assign slow_mask = ~({CNT_W{1'b1}} << act[NDOM-1]);
   assign wrap      = (cnt == slow_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         act <= '0;
      end else if (wrap) begin
         cnt <= '0;
         act <= pend;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   a_r6_load_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(act));
   a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt & ~slow_mask) == '0);
   generate
      for (genvar g = 1; g < NDOM; g++) begin : g_ord
         a_r3_act_ordered: assert property (@(posedge clk) disable iff (!rst_n)
            act[g] >= act[g-1]);
      end
   endgenerate
endmodule

// File: rtl/ps_domain_tap.sv
// Per-domain strobe and ratio decode from the shared phase counter.
module ps_domain_tap #(
   parameter int CODE_W = 3,
   localparam int CNT_W = (1 << CODE_W) - 1,
   localparam int DIV_W = 1 << CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code,
   input  logic [CNT_W-1:0]  cnt,
   output logic              en,
   output logic [DIV_W-1:0]  div
);
   assign en  = ((cnt & ~({CNT_W{1'b1}} << code)) == '0);
   assign div = DIV_W'(1) << code;

   a_r8_div1_high: assert property (@(posedge clk) disable iff (!rst_n)
      (code == '0) |-> en);
endmodule

// File: rtl/domain_prescaler.sv
module domain_prescaler
   import prescaler_pkg::*;
#(
   parameter int CODE_W = 3,
   localparam int DIV_W = 1 << CODE_W,
   localparam int CNT_W = (1 << CODE_W) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [CODE_W-1:0] wr_code,
   output logic              cpu_en,
   output logic              lp_en,
   output logic              bkp_en,
   output logic [DIV_W-1:0]  cpu_div,
   output logic [DIV_W-1:0]  lp_div,
   output logic [DIV_W-1:0]  bkp_div,
   output logic              order_err
);
   generate
      if (CODE_W < 1 || CODE_W > 5) begin : g_bad_code_w
         $error("domain_prescaler: CODE_W must lie in 1..5");
      end
   endgenerate

   logic [NDOM-1:0][CODE_W-1:0] pend;
   logic [NDOM-1:0][CODE_W-1:0] act;
   logic [CNT_W-1:0]            cnt;
   logic                        wrap;
   logic [NDOM-1:0]             en_v;
   logic [NDOM-1:0][DIV_W-1:0]  div_v;

   ps_cfg_regs #(.CODE_W(CODE_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_code(wr_code), .pend(pend), .err(order_err)
   );

   ps_align_counter #(.CODE_W(CODE_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .pend(pend), .act(act), .cnt(cnt), .wrap(wrap)
   );

   generate
      for (genvar g = 0; g < NDOM; g++) begin : g_tap
         ps_domain_tap #(.CODE_W(CODE_W)) u_tap (
            .clk(clk), .rst_n(rst_n), .code(act[g]), .cnt(cnt),
            .en(en_v[g]), .div(div_v[g])
         );
      end
   endgenerate

   assign cpu_en  = en_v[0];
   assign lp_en   = en_v[1];
   assign bkp_en  = en_v[2];
   assign cpu_div = div_v[0];
   assign lp_div  = div_v[1];
   assign bkp_div = div_v[2];

   a_r7_bkp_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      bkp_en |-> (lp_en && cpu_en));
   a_r7_lp_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      lp_en |-> cpu_en);
   a_r6_restart_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cpu_en && lp_en && bkp_en));
endmodule

// File: tb/domain_prescaler_bench.sv
`timescale 1ns/1ps
module domain_prescaler_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = 2'd0;
   logic [2:0] wr_code = 3'd0;
   logic       cpu_en, lp_en, bkp_en, order_err;
   logic [7:0] cpu_div, lp_div, bkp_div;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   domain_prescaler u_domain_prescaler (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_code(wr_code),
      .cpu_en(cpu_en), .lp_en(lp_en), .bkp_en(bkp_en),
      .cpu_div(cpu_div), .lp_div(lp_div), .bkp_div(bkp_div), .order_err(order_err)
   );

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic chk_divs(string req, int c, int l, int b);
      chk(req, "cpu_div", int'(cpu_div), c);
      chk(req, "lp_div",  int'(lp_div),  l);
      chk(req, "bkp_div", int'(bkp_div), b);
   endtask

   // scoreboard: expected pulse counts per window
   typedef struct {
      int    cyc;
      int    e_cpu;
      int    e_lp;
      int    e_bkp;
      string req;
   } win_t;
   win_t q[$];

   initial begin
      forever begin
         wait (q.size() > 0);
         begin
            win_t w;
            int   c_cpu, c_lp, c_bkp, mis;
            w = q[0];
            c_cpu = 0; c_lp = 0; c_bkp = 0; mis = 0;
            repeat (w.cyc) begin
               @(negedge clk);
               c_cpu += int'(cpu_en);
               c_lp  += int'(lp_en);
               c_bkp += int'(bkp_en);
               if ((bkp_en && !(lp_en && cpu_en)) || (lp_en && !cpu_en)) mis++;
            end
            chk(w.req, "cpu pulses", c_cpu, w.e_cpu);
            chk(w.req, "lp pulses",  c_lp,  w.e_lp);
            chk(w.req, "bkp pulses", c_bkp, w.e_bkp);
            chk("R7", "misaligned pulses", mis, 0);
            void'(q.pop_front());
         end
      end
   end

   task automatic expect_win(int cyc, int c, int l, int b, string req);
      win_t w;
      w.cyc = cyc; w.e_cpu = c; w.e_lp = l; w.e_bkp = b; w.req = req;
      q.push_back(w);
      wait (q.size() == 0);
   endtask

   task automatic wr_now(logic [1:0] sel, logic [2:0] code);
      wr_en = 1'b1; wr_sel = sel; wr_code = code;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wr(logic [1:0] sel, logic [2:0] code);
      @(negedge clk);
      wr_now(sel, code);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 4);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      chk_divs("R1", 1, 1, 1);
      chk("R1", "order_err", int'(order_err), 0);
      chk("R1", "all strobes", int'(cpu_en & lp_en & bkp_en), 1);
      // R8 ratio 1 strobes every cycle
      expect_win(16, 16, 16, 16, "R8");

      // R5 selector 3 ignored
      wr(2'd3, 3'd5);
      repeat (2) @(negedge clk);
      chk_divs("R5", 1, 1, 1);
      chk("R5", "order_err", int'(order_err), 0);

      // R3/R4 processor above low-power is rejected
      wr(2'd0, 3'd1);
      repeat (2) @(negedge clk);
      chk_divs("R3", 1, 1, 1);
      chk("R4", "order_err set", int'(order_err), 1);
      do_reset();
      chk("R4", "order_err cleared by reset", int'(order_err), 0);

      // R2 legal programming in order backup, low-power, processor
      wr(2'd2, 3'd3);
      repeat (2) @(negedge clk);
      chk("R2", "bkp_div", int'(bkp_div), 8);
      wr(2'd1, 3'd2);
      wr(2'd0, 3'd1);
      repeat (9) @(negedge clk);
      chk_divs("R2", 2, 4, 8);
      chk("R3", "order_err", int'(order_err), 0);
      expect_win(64, 32, 16, 8, "R2");

      // R6/R9 change in mid-period: old period completes, then realign
      do @(negedge clk); while (!bkp_en);
      wr_now(2'd2, 3'd5);
      repeat (6) @(negedge clk);
      chk("R9", "bkp_div before wrap", int'(bkp_div), 8);
      chk("R9", "bkp_en mid period", int'(bkp_en), 0);
      @(negedge clk);
      chk("R6", "bkp_div after wrap", int'(bkp_div), 32);
      chk("R9", "bkp_en after full old period", int'(bkp_en), 1);
      chk("R6", "all strobes after wrap", int'(cpu_en & lp_en & bkp_en), 1);
      expect_win(128, 64, 32, 4, "R2");

      // R3/R4 low-power above backup rejected, flag sticky over a legal write
      wr(2'd1, 3'd6);
      repeat (40) @(negedge clk);
      chk("R3", "lp_div unchanged", int'(lp_div), 4);
      chk("R4", "order_err set", int'(order_err), 1);
      wr(2'd1, 3'd5);
      repeat (34) @(negedge clk);
      chk("R3", "lp_div accepted", int'(lp_div), 32);
      chk("R4", "order_err sticky", int'(order_err), 1);

      // R2 largest ratio on every domain
      wr(2'd2, 3'd7);
      wr(2'd1, 3'd7);
      wr(2'd0, 3'd7);
      repeat (170) @(negedge clk);
      chk_divs("R2", 128, 128, 128);
      expect_win(256, 2, 2, 2, "R2");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule